// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a one-cycle arithmetic datapath for 32-bit words that never wraps silently. An opcode selects one of ten operations: signed or unsigned addition and subtraction with clamping, a signed addition that wraps but still reports overflow, signed doubling, and clamping a value into a programmable number of bits, either as a signed or unsigned quantity. Clamping can also run on the two 16-bit halves of a word at once, and each half is treated on its own.

Every operation that clamps, or that detects overflow in the wrapping add, raises a sticky saturation flag. Software, or a sequencer, reads this flag after a run of operations to learn whether any result in that run lost precision. The flag stays set until an explicit clear strobe drops it. Results are captured in an output register on each clock edge where the input is marked valid. Words are 32 bits wide, halves are 16 bits, and the clamp width is a 5-bit field. These sizes come from constants in the shared package.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 adds A and B as signed numbers. If A and B have the same sign and the sum's sign differs from A, the result is 0x7FFFFFFF when A is non-negative and 0x80000000 when A is negative, and the operation counts as saturating. Otherwise the result is the sum.
- R2: Opcode 1 returns the wrapped sum A+B in every case. It counts as saturating when the signed add overflows under the R1 rule.
- R3: Opcode 2 computes A−B. If A and B differ in sign and the difference's sign differs from A, it clamps as in R1 and counts as saturating. Otherwise the result is the difference.
- R4: Opcode 3 adds A and B as unsigned numbers. A carry out of bit 31 gives 0xFFFFFFFF and counts as saturating.
- R5: Opcode 4 computes A−B unsigned. A borrow gives 0 and counts as saturating.
- R6: Opcode 5 doubles A and ignores B. A signed A of 0x40000000 or more gives 0x7FFFFFFF. A signed A of 0xC0000000 or less gives 0x80000000. Both clamps count as saturating. Any other A gives A shifted left by one.
- R7: Opcode 6 clamps the signed word A to width n, where n is the 5-bit width input. With m = 2^n−1: if A arithmetically shifted right by n is above 0, the result is m; if it is below −1, the result is ~m. Either case counts as saturating. Otherwise A passes through unchanged. B is ignored.
- R8: Opcode 7 clamps A as an unsigned value to width n. A negative A gives 0. An A above 2^n−1 gives 2^n−1. Both count as saturating. Otherwise A passes through unchanged.
- R9: Opcodes 8 (signed, rule of R7) and 9 (unsigned, rule of R8) sign-extend bits 15:0 and bits 31:16 of A separately and clamp each to width n. The low 16 bits of each result are placed back into the same half. The operation counts as saturating if either half clamps.
- R10: The sticky flag goes to 1 after a valid saturating operation. It never falls except through the clear strobe, which drives it to 0 and wins over a saturating operation in the same cycle. Operations without valid do not touch it.
- R11: The result register loads the selected operation's value on the rising edge where valid is high, so it shows one edge after the inputs. It holds its value while valid is low. The clear strobe does not block the result from loading.
- R12: A synchronous active-high reset sets the result to 0 and the flag to 0, and takes priority over a valid operation.
- R13: Opcodes 10 to 15 load a result of 0 and do not count as saturating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Operation select, encoding as in R1 to R13 |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| sat_width | input | 5 | Clamp width n for opcodes 6 to 9 |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench uses the package defaults: 32-bit words, 16-bit halves and a 5-bit clamp width. With these sizes the full range of clamp widths is covered, from n = 0 (signed results pinned to 0 or −1, unsigned results pinned to 0) up to n = 31, where a signed clamp can never trigger. The dual-half modes are run at n = 15, where the mask equals the largest positive half and the boundary is exact. Doubling is tested on both sides of 0x40000000 and 0xC0000000. Carry and borrow are tested at their edges, where results such as 0xFFFFFFFE + 1 come out exact and must not set the flag.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = WORD_W / 2;
    localparam int unsigned LANES   = WORD_W / HALF_W;
    localparam int unsigned SHAMT_W = $clog2(WORD_W);
    localparam int unsigned OP_W    = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADDS      = 4'd0,
        OP_ADDS_WRAP = 4'd1,
        OP_SUBS      = 4'd2,
        OP_ADDU      = 4'd3,
        OP_SUBU      = 4'd4,
        OP_DBLS      = 4'd5,
        OP_CLPS      = 4'd6,
        OP_CLPU      = 4'd7,
        OP_CLPS_DUAL = 4'd8,
        OP_CLPU_DUAL = 4'd9
    } sat_op_e;

    typedef struct packed {
        word_t value;
        logic  sat;
    } sat_res_t;

    // Largest positive two's-complement word.
    function automatic word_t pos_limit();
        return {1'b0, {(WORD_W-1){1'b1}}};
    endfunction

    // Most negative two's-complement word.
    function automatic word_t neg_limit();
        return {1'b1, {(WORD_W-1){1'b0}}};
    endfunction

    // Clamp value chosen by the sign of the first operand.
    function automatic word_t signed_rail(input logic neg);
        return neg ? neg_limit() : pos_limit();
    endfunction

    function automatic word_t sext_half(input half_t h);
        return {{(WORD_W-HALF_W){h[HALF_W-1]}}, h};
    endfunction

    // 2^n - 1 for a shift amount n.
    function automatic word_t low_mask(input logic [SHAMT_W-1:0] n);
        return ~({WORD_W{1'b1}} << n);
    endfunction

    function automatic logic is_clamp_op(input sat_op_e op);
        return (op == OP_CLPS) || (op == OP_CLPU) ||
               (op == OP_CLPS_DUAL) || (op == OP_CLPU_DUAL);
    endfunction

    function automatic logic is_arith_op(input sat_op_e op);
        return (op == OP_ADDS) || (op == OP_ADDS_WRAP) || (op == OP_SUBS) ||
               (op == OP_ADDU) || (op == OP_SUBU) || (op == OP_DBLS);
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_alu_pkg::*;
(
    input  word_t    a,
    input  word_t    b,
    input  sat_op_e  op,
    output sat_res_t res
);
    localparam int unsigned MSB = WORD_W - 1;
    localparam word_t QUARTER   = word_t'(1) << (WORD_W - 2);
    localparam word_t NEG_QTR   = ~QUARTER + word_t'(1);

    word_t sum, dif, dbl;
    logic  carry, borrow;
    logic  s_add_ovf, s_sub_ovf;
    logic  dbl_hi, dbl_lo;

    assign {carry, sum}  = {1'b0, a} + {1'b0, b};
    assign {borrow, dif} = {1'b0, a} - {1'b0, b};

    assign s_add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    assign s_sub_ovf = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);

    assign dbl_hi = $signed(a) >= $signed(QUARTER);
    assign dbl_lo = $signed(a) <= $signed(NEG_QTR);
    assign dbl    = {a[MSB-1:0], 1'b0};

    always_comb begin
        res = '0;
        unique case (op)
            OP_ADDS: begin
                res.value = s_add_ovf ? signed_rail(a[MSB]) : sum;
                res.sat   = s_add_ovf;
            end
            OP_ADDS_WRAP: begin
                res.value = sum;
                res.sat   = s_add_ovf;
            end
            OP_SUBS: begin
                res.value = s_sub_ovf ? signed_rail(a[MSB]) : dif;
                res.sat   = s_sub_ovf;
            end
            OP_ADDU: begin
                res.value = carry ? {WORD_W{1'b1}} : sum;
                res.sat   = carry;
            end
            OP_SUBU: begin
                res.value = borrow ? '0 : dif;
                res.sat   = borrow;
            end
            OP_DBLS: begin
                if (dbl_hi)      res.value = pos_limit();
                else if (dbl_lo) res.value = neg_limit();
                else             res.value = dbl;
                res.sat = dbl_hi || dbl_lo;
            end
            default: res = '0;
        endcase
    end

    // A clamped signed add or subtract keeps the sign of operand A (R1, R3).
    always_comb begin
        if ((op == OP_ADDS || op == OP_SUBS) && res.sat) begin
            assert_rail_sign_R1: assert (res.value[MSB] == a[MSB]);
        end
    end

    // A clamped doubling lands on a rail whose sign matches the input (R6).
    always_comb begin
        if (op == OP_DBLS && res.sat) begin
            assert_dbl_rail_R6: assert ((res.value == pos_limit() && !a[MSB]) ||
                                        (res.value == neg_limit() &&  a[MSB]));
        end
    end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_alu_pkg::*;
(
    input  word_t              din,
    input  logic [SHAMT_W-1:0] width,
    input  logic               is_signed,
    output word_t              dout,
    output logic               sat
);
    localparam int unsigned MSB = WORD_W - 1;

    word_t mask;
    word_t top;
    logic  top_pos, top_below_m1;
    logic  u_neg, u_over;

    assign mask = low_mask(width);
    assign top  = word_t'($signed(din) >>> width);

    // top > 0 : non-negative and non-zero; top < -1 : negative and not all ones.
    assign top_pos      = !top[MSB] && (|top);
    assign top_below_m1 =  top[MSB] && !(&top);

    assign u_neg  = din[MSB];
    assign u_over = !din[MSB] && (din > mask);

    always_comb begin
        dout = din;
        sat  = 1'b0;
        if (is_signed) begin
            if (top_pos) begin
                dout = mask;
                sat  = 1'b1;
            end else if (top_below_m1) begin
                dout = ~mask;
                sat  = 1'b1;
            end
        end else begin
            if (u_neg) begin
                dout = '0;
                sat  = 1'b1;
            end else if (u_over) begin
                dout = mask;
                sat  = 1'b1;
            end
        end
    end

    // Output always lies inside the representable range of width n (R7, R8).
    always_comb begin
        if (is_signed) begin
            assert_range_signed_R7: assert ($signed(dout) <= $signed(mask) &&
                                            $signed(dout) >= $signed(~mask));
        end else begin
            assert_range_unsigned_R8: assert (dout <= mask);
        end
    end

endmodule

// File: rtl/sat_lanes.sv
module sat_lanes
    import sat_alu_pkg::*;
(
    input  word_t              din,
    input  logic [SHAMT_W-1:0] width,
    input  logic               is_signed,
    input  logic               dual,
    output sat_res_t           res
);
    word_t              full_val;
    logic               full_sat;
    word_t              lane_val [LANES];
    logic [LANES-1:0]   lane_sat;
    word_t              packed_val;

    sat_clamp u_full (
        .din       (din),
        .width     (width),
        .is_signed (is_signed),
        .dout      (full_val),
        .sat       (full_sat)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp u_lane (
            .din       (sext_half(din[g*HALF_W +: HALF_W])),
            .width     (width),
            .is_signed (is_signed),
            .dout      (lane_val[g]),
            .sat       (lane_sat[g])
        );

        assign packed_val[g*HALF_W +: HALF_W] = lane_val[g][HALF_W-1:0];

        // A clamped half always fits back into 16 bits, so packing loses nothing (R9).
        always_comb begin
            assert_lane_fits_R9: assert (lane_val[g][WORD_W-1:HALF_W] ==
                                         {(WORD_W-HALF_W){lane_val[g][HALF_W-1]}});
        end
    end

    always_comb begin
        if (dual) begin
            res.value = packed_val;
            res.sat   = |lane_sat;
        end else begin
            res.value = full_val;
            res.sat   = full_sat;
        end
    end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [WORD_W-1:0]   opnd_a,
    input  logic [WORD_W-1:0]   opnd_b,
    input  logic [SHAMT_W-1:0]  sat_width,
    input  logic                flag_clr,
    output logic [WORD_W-1:0]   result,
    output logic                sat_flag
);
    sat_op_e  op_e;
    sat_res_t arith_res, clamp_res, nxt;
    logic     clamp_signed, clamp_dual;

    assign op_e         = sat_op_e'(op);
    assign clamp_signed = (op_e == OP_CLPS) || (op_e == OP_CLPS_DUAL);
    assign clamp_dual   = (op_e == OP_CLPS_DUAL) || (op_e == OP_CLPU_DUAL);

    sat_addsub u_arith (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (op_e),
        .res (arith_res)
    );

    sat_lanes u_clamp (
        .din       (opnd_a),
        .width     (sat_width),
        .is_signed (clamp_signed),
        .dual      (clamp_dual),
        .res       (clamp_res)
    );

    always_comb begin
        if (is_arith_op(op_e))      nxt = arith_res;
        else if (is_clamp_op(op_e)) nxt = clamp_res;
        else                        nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            sat_flag <= 1'b0;
        end else begin
            if (in_valid) result <= nxt.value;
            if (flag_clr)
                sat_flag <= 1'b0;
            else if (in_valid && nxt.sat)
                sat_flag <= 1'b1;
        end
    end

    // Clear strobe wins over everything (R10).
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> !sat_flag);

    // Once set, the flag holds until cleared (R10).
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !flag_clr) |=> sat_flag);

    // A valid saturating operation raises the flag (R10).
    assert_flag_raise_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nxt.sat && !flag_clr) |=> sat_flag);

    // The flag never rises without a valid saturating operation (R10).
    assert_flag_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!sat_flag && !(in_valid && nxt.sat)) |=> !sat_flag);

    // Result holds while no valid input arrives (R11).
    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

endmodule

// File: tb/sat_alu_tb.sv
module sat_alu_tb;
    import sat_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  sat_width;
    logic        flag_clr;
    logic [31:0] result;
    logic        sat_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    sat_alu u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .sat_width (sat_width),
        .flag_clr  (flag_clr),
        .result    (result),
        .sat_flag  (sat_flag)
    );

    // {req, op, width, a, b, expected result, expected flag}
    localparam int NV = 38;
    localparam logic [109:0] VEC [NV] = '{
        {4'd1, 4'd0, 5'd0,  32'h7FFF_FFF0, 32'h0000_0020, 32'h7FFF_FFFF, 1'b1}, // R1 positive overflow
        {4'd1, 4'd0, 5'd0,  32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1}, // R1 negative overflow
        {4'd1, 4'd0, 5'd0,  32'h0000_0005, 32'hFFFF_FFFD, 32'h0000_0002, 1'b0}, // R1 no overflow
        {4'd2, 4'd1, 5'd0,  32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1}, // R2 wraps, flags
        {4'd2, 4'd1, 5'd0,  32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 1'b0}, // R2 plain
        {4'd3, 4'd2, 5'd0,  32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b1}, // R3 negative rail
        {4'd3, 4'd2, 5'd0,  32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1}, // R3 positive rail
        {4'd3, 4'd2, 5'd0,  32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0}, // R3 plain
        {4'd4, 4'd3, 5'd0,  32'hFFFF_FFF0, 32'h0000_0020, 32'hFFFF_FFFF, 1'b1}, // R4 carry
        {4'd4, 4'd3, 5'd0,  32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b0}, // R4 plain
        {4'd4, 4'd3, 5'd0,  32'hFFFF_FFFE, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0}, // R4 exact top
        {4'd5, 4'd4, 5'd0,  32'h0000_0005, 32'h0000_0006, 32'h0000_0000, 1'b1}, // R5 borrow
        {4'd5, 4'd4, 5'd0,  32'h0000_0006, 32'h0000_0006, 32'h0000_0000, 1'b0}, // R5 exact zero
        {4'd5, 4'd4, 5'd0,  32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0}, // R5 unsigned view
        {4'd6, 4'd5, 5'd0,  32'h4000_0000, 32'h1234_5678, 32'h7FFF_FFFF, 1'b1}, // R6 upper bound
        {4'd6, 4'd5, 5'd0,  32'h3FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFE, 1'b0}, // R6 just below
        {4'd6, 4'd5, 5'd0,  32'hC000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1}, // R6 lower bound
        {4'd6, 4'd5, 5'd0,  32'hC000_0001, 32'h0000_0000, 32'h8000_0002, 1'b0}, // R6 just above
        {4'd6, 4'd5, 5'd0,  32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFE, 1'b0}, // R6 minus one
        {4'd7, 4'd6, 5'd7,  32'h0000_0100, 32'hDEAD_BEEF, 32'h0000_007F, 1'b1}, // R7 high clamp
        {4'd7, 4'd6, 5'd7,  32'hFFFF_FF00, 32'h0000_0000, 32'hFFFF_FF80, 1'b1}, // R7 low clamp
        {4'd7, 4'd6, 5'd7,  32'h0000_007F, 32'h0000_0000, 32'h0000_007F, 1'b0}, // R7 max passes
        {4'd7, 4'd6, 5'd7,  32'hFFFF_FF80, 32'h0000_0000, 32'hFFFF_FF80, 1'b0}, // R7 min passes
        {4'd7, 4'd6, 5'd0,  32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R7 width zero
        {4'd7, 4'd6, 5'd31, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0}, // R7 width 31
        {4'd8, 4'd7, 5'd8,  32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R8 negative
        {4'd8, 4'd7, 5'd8,  32'h0000_0100, 32'h0000_0000, 32'h0000_00FF, 1'b1}, // R8 over
        {4'd8, 4'd7, 5'd8,  32'h0000_00FF, 32'h0000_0000, 32'h0000_00FF, 1'b0}, // R8 at max
        {4'd8, 4'd7, 5'd0,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R8 width zero
        {4'd9, 4'd8, 5'd7,  32'h0100_FF00, 32'h0000_0000, 32'h007F_FF80, 1'b1}, // R9 both halves
        {4'd9, 4'd8, 5'd7,  32'h0005_0100, 32'h0000_0000, 32'h0005_007F, 1'b1}, // R9 low half only
        {4'd9, 4'd8, 5'd7,  32'h003F_FFC0, 32'h0000_0000, 32'h003F_FFC0, 1'b0}, // R9 in range
        {4'd9, 4'd8, 5'd15, 32'h8000_7FFF, 32'h0000_0000, 32'h8000_7FFF, 1'b0}, // R9 width 15 signed
        {4'd9, 4'd9, 5'd4,  32'hFFFF_0020, 32'h0000_0000, 32'h0000_000F, 1'b1}, // R9 unsigned both
        {4'd9, 4'd9, 5'd4,  32'h000A_0003, 32'h0000_0000, 32'h000A_0003, 1'b0}, // R9 unsigned pass
        {4'd9, 4'd9, 5'd15, 32'h8000_7FFF, 32'h0000_0000, 32'h0000_7FFF, 1'b1}, // R9 high half neg
        {4'd13, 4'd10, 5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R13 opcode 10
        {4'd13, 4'd15, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}  // R13 opcode 15
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic c, input logic [3:0] o,
                         input logic [31:0] a, input logic [31:0] b, input logic [4:0] w);
        in_valid  = v;
        flag_clr  = c;
        op        = o;
        opnd_a    = a;
        opnd_b    = b;
        sat_width = w;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 4'd0, '0, '0, '0);
        repeat (3) @(posedge clk);
        #1;
        chk(12, result, 32'h0, "reset result");      // R12
        chk(12, {31'b0, sat_flag}, 32'h0, "reset flag"); // R12
        @(negedge clk);
        rst = 1'b0;

        // Table walk: clear the flag, then apply one vector.
        for (int i = 0; i < NV; i++) begin
            logic [109:0] v;
            v = VEC[i];
            @(negedge clk);
            drive(1'b0, 1'b1, 4'd0, '0, '0, '0);
            @(negedge clk);
            drive(1'b1, 1'b0, v[105:102], v[96:65], v[64:33], v[101:97]);
            @(posedge clk);
            #1;
            chk(int'(v[109:106]), result, v[32:1], "vector result");
            chk(int'(v[109:106]), {31'b0, sat_flag}, {31'b0, v[0]}, "vector flag");
        end

        // R11: one-edge latency and hold while idle.
        @(negedge clk);
        drive(1'b1, 1'b1, 4'd3, 32'h1, 32'h2, '0);
        @(posedge clk); #1;
        chk(11, result, 32'h3, "load");
        @(negedge clk);
        drive(1'b0, 1'b0, 4'd0, 32'h100, 32'h200, '0);
        repeat (2) @(posedge clk);
        #1;
        chk(11, result, 32'h3, "hold while idle");
        @(negedge clk);
        drive(1'b1, 1'b0, 4'd3, 32'h7, 32'h8, '0);
        #1;
        chk(11, result, 32'h3, "no change before edge");
        @(posedge clk); #1;
        chk(11, result, 32'hF, "update at edge");

        // R10: sticky behaviour and clear priority.
        @(negedge clk);
        drive(1'b0, 1'b1, 4'd0, '0, '0, '0);
        @(negedge clk);
        drive(1'b1, 1'b0, 4'd3, 32'hFFFF_FFFF, 32'h1, '0);
        @(posedge clk); #1;
        chk(10, {31'b0, sat_flag}, 32'h1, "flag raised");
        @(negedge clk);
        drive(1'b1, 1'b0, 4'd3, 32'h1, 32'h1, '0);
        @(posedge clk); #1;
        chk(10, {31'b0, sat_flag}, 32'h1, "flag sticky");
        chk(11, result, 32'h2, "result after sticky op");
        @(negedge clk);
        drive(1'b0, 1'b1, 4'd0, '0, '0, '0);
        @(posedge clk); #1;
        chk(10, {31'b0, sat_flag}, 32'h0, "flag cleared");
        @(negedge clk);
        drive(1'b1, 1'b1, 4'd3, 32'hFFFF_FFFF, 32'h5, '0);
        @(posedge clk); #1;
        chk(10, {31'b0, sat_flag}, 32'h0, "clear beats saturation");
        chk(11, result, 32'hFFFF_FFFF, "result loads during clear");
        @(negedge clk);
        drive(1'b0, 1'b0, 4'd3, 32'hFFFF_FFFF, 32'h5, '0);
        @(posedge clk); #1;
        chk(10, {31'b0, sat_flag}, 32'h0, "invalid op leaves flag");

        // R12: reset mid-run beats a valid saturating operation.
        @(negedge clk);
        drive(1'b1, 1'b0, 4'd0, 32'h7FFF_FFFF, 32'h1, '0);
        @(posedge clk); #1;
        chk(1, result, 32'h7FFF_FFFF, "pre-reset op");
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 1'b0, 4'd3, 32'hFFFF_FFFF, 32'h9, '0);
        @(posedge clk); #1;
        chk(12, result, 32'h0, "mid reset result");
        chk(12, {31'b0, sat_flag}, 32'h0, "mid reset flag");
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 4'd0, '0, '0, '0);
        @(posedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule